// File: doc/BRIEF.md
# Auto-Reload Interval Timer

This block is one timer channel with an 8-bit up-counter that advances once per machine-cycle tick. The tick arrives as an enable input, and a run control gates it. When the counter passes its all-ones value, it does not wrap to zero. It takes its next value from a separate reload register and raises an overflow flag for the interrupt controller. Software only writes the reload register, so the time between overflows is fixed at (256 − reload) ticks. For example, a reload of 0x5A gives 166 ticks, which is about 166 µs when a tick lasts 1 µs.

Software first writes the reload value, then writes the same value into the counter, then sets the run bit. The flag clears when the interrupt controller acknowledges this timer's vector, or when software writes zero to the flag bit. A new reload value written while the timer runs takes effect at the next overflow.

Top module: `reload_timer8`

## Requirements
- R1: After reset the counter, the reload register, the run bit and the overflow flag all read zero.
- R2: When the run bit is 1 and `tickEn` is 1, the counter rises by one per clock. When either of them is 0, the counter holds its value.
- R3: A counting step taken from 0xFF loads the counter with the reload register value, and the reload register keeps its value. Starting from a count equal to the reload value r, the overflow comes on the (256 − r)th tick.
- R4: An overflow sets `ovfFlag`, and the flag is visible in the clock after the overflowing tick.
- R5: `intAck` high clears the flag. A write to the control register with bit 1 = 0 also clears it. A control write with bit 1 = 1 leaves the flag as it was.
- R6: When an overflow falls in the same cycle as an acknowledge or a software clear, the flag ends up set.
- R7: A counter write takes priority over counting in the same cycle. The counter then takes the written value, and no overflow or flag set occurs.
- R8: A reload write made while the timer runs is used at the next overflow. If the write falls in the overflow cycle itself, that overflow still loads the old reload value.
- R9: The write decode is: address 0 writes the counter, address 1 writes the reload register, and address 2 writes the control register (bit 0 = run, bit 1 = flag clear-by-zero). A write to address 3 changes nothing.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| tickEn | input | 1 | One-cycle machine-cycle tick |
| wrEn | input | 1 | Register write strobe |
| wrAddr | input | 2 | Register select for the write |
| wrData | input | 8 | Write data |
| intAck | input | 1 | Interrupt controller vectored to this timer |
| countVal | output | 8 | Current counter value |
| reloadVal | output | 8 | Reload register value |
| runBit | output | 1 | Run control state |
| ovfFlag | output | 1 | Overflow flag |

## Verification
Two kinds of event can fall in the same cycle. An overflow can coincide with a flag clear (acknowledge or software write). A counting step can coincide with a software write to the counter or to the reload register. The bench parks the counter at 0xFF with the run bit set, then raises the tick in the same cycle as the competing strobe. It judges the result one clock later from the flag, the counter and the reload value. A sweep over all 256 reload values checks the tick on which each overflow falls and the value it reloads.

// File: rtl/rtmr_pkg.sv
package rtmr_pkg;
  localparam int unsigned DATA_W   = 8;
  localparam int unsigned ADDR_W   = 2;
  localparam logic [ADDR_W-1:0] ADDR_CNT = 2'd0;
  localparam logic [ADDR_W-1:0] ADDR_REL = 2'd1;
  localparam logic [ADDR_W-1:0] ADDR_CTL = 2'd2;
  localparam int unsigned RUN_BIT  = 0;
  localparam int unsigned FLAG_BIT = 1;

  typedef struct packed {
    logic loadCnt;
    logic loadRel;
    logic stepCnt;
    logic reloadCnt;
  } rtmrStrobe_t;
endpackage

// File: rtl/rtmr_datapath.sv
module rtmr_datapath
  import rtmr_pkg::*;
#(
  parameter int unsigned W = DATA_W
) (
  input  logic         clk,
  input  logic         rstN,
  input  rtmrStrobe_t  stb,
  input  logic [W-1:0] wrData,
  output logic [W-1:0] countQ,
  output logic [W-1:0] reloadQ,
  output logic         cntAtMax
);
  localparam logic [W-1:0] ONE = {{(W-1){1'b0}}, 1'b1};

  always_ff @(posedge clk) begin
    if (!rstN) begin
      countQ <= '0;
    end else if (stb.loadCnt) begin
      countQ <= wrData;
    end else if (stb.reloadCnt) begin
      countQ <= reloadQ;
    end else if (stb.stepCnt) begin
      countQ <= countQ + ONE;
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      reloadQ <= '0;
    end else if (stb.loadRel) begin
      reloadQ <= wrData;
    end
  end

  assign cntAtMax = &countQ;

  // R3
  reload_value_chk: assert property (@(posedge clk) disable iff (!rstN)
    stb.reloadCnt |=> countQ == $past(reloadQ));

  // R3
  reload_hold_chk: assert property (@(posedge clk) disable iff (!rstN)
    !stb.loadRel |=> $stable(reloadQ));

  // R7
  count_write_chk: assert property (@(posedge clk) disable iff (!rstN)
    stb.loadCnt |=> countQ == $past(wrData));
endmodule

// File: rtl/rtmr_ctrl.sv
module rtmr_ctrl
  import rtmr_pkg::*;
(
  input  logic              clk,
  input  logic              rstN,
  input  logic              tickEn,
  input  logic              wrEn,
  input  logic [ADDR_W-1:0] wrAddr,
  input  logic              ctlRun,
  input  logic              ctlFlag,
  input  logic              intAck,
  input  logic              cntAtMax,
  output rtmrStrobe_t       stb,
  output logic              runQ,
  output logic              flagQ
);
  logic wrCnt, wrRel, wrCtl, counting, swClear;

  assign wrCnt    = wrEn && (wrAddr == ADDR_CNT);
  assign wrRel    = wrEn && (wrAddr == ADDR_REL);
  assign wrCtl    = wrEn && (wrAddr == ADDR_CTL);
  assign counting = runQ && tickEn && !wrCnt;
  assign swClear  = wrCtl && !ctlFlag;

  always_comb begin
    stb.loadCnt   = wrCnt;
    stb.loadRel   = wrRel;
    stb.stepCnt   = counting && !cntAtMax;
    stb.reloadCnt = counting && cntAtMax;
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      runQ <= 1'b0;
    end else if (wrCtl) begin
      runQ <= ctlRun;
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      flagQ <= 1'b0;
    end else if (stb.reloadCnt) begin
      flagQ <= 1'b1;
    end else if (intAck || swClear) begin
      flagQ <= 1'b0;
    end
  end

  // R6
  set_wins_chk: assert property (@(posedge clk) disable iff (!rstN)
    stb.reloadCnt |=> flagQ);

  // R4
  flag_source_chk: assert property (@(posedge clk) disable iff (!rstN)
    $rose(flagQ) |-> $past(stb.reloadCnt));

  // R5
  ack_clear_chk: assert property (@(posedge clk) disable iff (!rstN)
    (intAck && !stb.reloadCnt) |=> !flagQ);

  // R7
  no_overflow_chk: assert property (@(posedge clk) disable iff (!rstN)
    wrCnt |-> !(stb.stepCnt || stb.reloadCnt));
endmodule

// File: rtl/reload_timer8.sv
module reload_timer8
  import rtmr_pkg::*;
(
  input  logic              clk,
  input  logic              rstN,
  input  logic              tickEn,
  input  logic              wrEn,
  input  logic [ADDR_W-1:0] wrAddr,
  input  logic [DATA_W-1:0] wrData,
  input  logic              intAck,
  output logic [DATA_W-1:0] countVal,
  output logic [DATA_W-1:0] reloadVal,
  output logic              runBit,
  output logic              ovfFlag
);
  rtmrStrobe_t stb;
  logic        cntAtMax;

  rtmr_ctrl uCtrl (
    .clk      (clk),
    .rstN     (rstN),
    .tickEn   (tickEn),
    .wrEn     (wrEn),
    .wrAddr   (wrAddr),
    .ctlRun   (wrData[RUN_BIT]),
    .ctlFlag  (wrData[FLAG_BIT]),
    .intAck   (intAck),
    .cntAtMax (cntAtMax),
    .stb      (stb),
    .runQ     (runBit),
    .flagQ    (ovfFlag)
  );

  rtmr_datapath #(.W(DATA_W)) uDp (
    .clk      (clk),
    .rstN     (rstN),
    .stb      (stb),
    .wrData   (wrData),
    .countQ   (countVal),
    .reloadQ  (reloadVal),
    .cntAtMax (cntAtMax)
  );

  // R2
  hold_when_idle_chk: assert property (@(posedge clk) disable iff (!rstN)
    (!(runBit && tickEn) && !(wrEn && wrAddr == ADDR_CNT)) |=> $stable(countVal));
endmodule

// File: tb/sim_reload_timer8.sv
`timescale 1ns/1ps
module sim_reload_timer8;
  logic       clk = 1'b0;
  logic       rstN = 1'b0;
  logic       tickEn = 1'b0;
  logic       wrEn = 1'b0;
  logic [1:0] wrAddr = 2'd0;
  logic [7:0] wrData = 8'd0;
  logic       intAck = 1'b0;
  logic [7:0] countVal, reloadVal;
  logic       runBit, ovfFlag;
  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  always #4 clk = ~clk;

  reload_timer8 u0 (
    .clk(clk), .rstN(rstN), .tickEn(tickEn), .wrEn(wrEn), .wrAddr(wrAddr),
    .wrData(wrData), .intAck(intAck), .countVal(countVal),
    .reloadVal(reloadVal), .runBit(runBit), .ovfFlag(ovfFlag)
  );

  task automatic chk(string req, int act, int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic wr(logic [1:0] a, logic [7:0] d);
    wrEn = 1'b1; wrAddr = a; wrData = d;
    @(negedge clk);
    wrEn = 1'b0;
  endtask

  task automatic ticks(int n);
    tickEn = 1'b1;
    repeat (n) @(negedge clk);
    tickEn = 1'b0;
  endtask

  initial begin
    #(8ns * 200000);
    if (!done) begin
      errors++;
      $display("FAIL watchdog: actual hung expected finish");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);
    chk("R1 count", countVal, 0);
    chk("R1 reload", reloadVal, 0);
    chk("R1 run", runBit, 0);
    chk("R1 flag", ovfFlag, 0);

    // R9 address 3 ignored
    wr(2'd3, 8'hFF);
    chk("R9 count", countVal, 0);
    chk("R9 reload", reloadVal, 0);
    chk("R9 run", runBit, 0);

    // R3 / R4 / R5 sweep of every reload value
    for (int r = 0; r < 256; r++) begin
      wr(2'd1, 8'(r));
      wr(2'd0, 8'(r));
      wr(2'd2, 8'h01);
      ticks(255 - r);
      chk("R2 count before overflow", countVal, 255);
      chk("R4 flag before overflow", ovfFlag, 0);
      ticks(1);
      chk("R3 reloaded count", countVal, r);
      chk("R3 reload kept", reloadVal, r);
      chk("R4 flag set", ovfFlag, 1);
      intAck = 1'b1; @(negedge clk); intAck = 1'b0;
      chk("R5 ack clears", ovfFlag, 0);
      wr(2'd2, 8'h00);
    end

    // R2 gated ticks
    wr(2'd0, 8'h10);
    wr(2'd2, 8'h01);
    for (int i = 0; i < 10; i++) begin
      tickEn = (i % 2 == 0); @(negedge clk);
    end
    tickEn = 1'b0;
    chk("R2 alternate ticks", countVal, 8'h15);
    wr(2'd2, 8'h00);
    ticks(7);
    chk("R2 run low holds", countVal, 8'h15);

    // R7 counter write beats a counting step at 0xFF
    wr(2'd1, 8'h40);
    wr(2'd0, 8'hFF);
    wr(2'd2, 8'h01);
    tickEn = 1'b1; wrEn = 1'b1; wrAddr = 2'd0; wrData = 8'h10;
    @(negedge clk);
    tickEn = 1'b0; wrEn = 1'b0;
    chk("R7 write wins", countVal, 8'h10);
    chk("R7 no flag", ovfFlag, 0);

    // R6 overflow together with ack and software clear
    wr(2'd0, 8'hFF);
    tickEn = 1'b1; intAck = 1'b1; wrEn = 1'b1; wrAddr = 2'd2; wrData = 8'h01;
    @(negedge clk);
    tickEn = 1'b0; intAck = 1'b0; wrEn = 1'b0;
    chk("R6 set wins", ovfFlag, 1);
    chk("R6 count reloaded", countVal, 8'h40);

    // R5 software write of 1 keeps, of 0 clears
    wr(2'd2, 8'h03);
    chk("R5 write one keeps", ovfFlag, 1);
    wr(2'd2, 8'h01);
    chk("R5 write zero clears", ovfFlag, 0);

    // R8 reload write in the overflow cycle
    wr(2'd0, 8'hFF);
    tickEn = 1'b1; wrEn = 1'b1; wrAddr = 2'd1; wrData = 8'h80;
    @(negedge clk);
    tickEn = 1'b0; wrEn = 1'b0;
    chk("R8 old reload used", countVal, 8'h40);
    chk("R8 new reload stored", reloadVal, 8'h80);
    ticks(8'hBF);
    chk("R8 before next overflow", countVal, 8'hFF);
    ticks(1);
    chk("R8 new reload used", countVal, 8'h80);

    done = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule